// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block manages the low-power state of a small microcontroller-style chip. The CPU asks for power-down by writing a single control bit. The block then turns off the oscillator enable and the PLL enable and waits for a wake request. Three sources can end power-down: a bus-activity indication, a main wake pin and an auxiliary wake pin. The auxiliary pin can also be set aside as a general-purpose input, and in that mode it does not wake the chip. Both pins pass through a two-flop synchronizer. Each pin has a programmable polarity, and after reset both pins are active low.

On a wake request the block restarts the clocks in a fixed order. It enables the oscillator first and counts a programmable number of cycles as the oscillator settle time. Next it enables the PLL and waits for the lock input. Only after that does it raise a one-cycle wakeup interrupt to the CPU. On that same cycle the power-down bit clears itself. A status register records which sources were active when power-down ended, and the CPU clears it by writing ones. Wake behaviour does not depend on whether the bus is attached. Bus activity is treated as one more active-high source.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset, osc_en and pll_en are 1 and wake_irq is 0. The registers read as follows: control (address 0) reads 0, config (address 1) reads 0, status (address 2) reads 0, and settle delay (address 3) reads DEF_DELAY.
- R2: Writing data bit 0 = 1 to address 0 requests power-down. osc_en and pll_en are both 0 by the second clock edge after the write edge, and they stay 0 until a wake request arrives.
- R3: Every wake input passes through two synchronizer flops. A pin that changes to its active level before edge N starts the wake sequence at edge N+2, and osc_en is 1 after that edge.
- R4: When a wake is taken, osc_en rises first. pll_en rises exactly settle-delay + 1 cycles later, and the pll_locked input is not looked at before then.
- R5: While pll_en is 1, the block waits as long as pll_locked stays 0. wake_irq is a single-cycle pulse, and it comes only on the cycle after pll_locked was sampled as 1.
- R6: Config bit 0 sets the polarity of the main pin and config bit 1 sets the polarity of the auxiliary pin. A value of 0 means active low and a value of 1 means active high. bus_activity is always active high.
- R7: When config bit 2 is 1, the auxiliary pin is a general-purpose input. It neither wakes the chip nor sets its status flag.
- R8: Control bit 0 clears itself on the wake_irq cycle and reads back 0 after it.
- R9: A wake source that becomes active while the chip is awake is ignored. No interrupt is raised, no status bit is set, and the clock enables stay 1.
- R10: The status register is at address 2. Bit 0 is bus activity, bit 1 is the main pin and bit 2 is the auxiliary pin. The block sets a bit for every qualified source that is active on the edge that ends power-down. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock for the sequencer |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| bus_activity | input | 1 | Bus activity indication, active high |
| main_wake_pin | input | 1 | Dedicated wake pin |
| aux_wake_pin | input | 1 | Shared wake or general-purpose pin |
| pll_locked | input | 1 | Lock indication from the PLL |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| wake_irq | output | 1 | One-cycle wakeup interrupt |

## Verification
The bench holds pll_locked high for the whole of one power-down. A design that samples lock before the settle count runs out would enable the PLL or interrupt early, and the measured osc-to-PLL spacing would be wrong. The spacing is also measured with a zero delay, where an off-by-one counter shows up at once. Pins are driven at their inactive polarity, and the auxiliary pin is driven while it is in general-purpose mode. A design with inverted polarity or a missing mode gate would wake from these, and osc_en would rise. Wake sources are pulsed while the chip is awake, and write-zero is applied to status bits. A design that latches flags outside power-down, or that clears on any write, leaves a wrong status value behind.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_OSC_WAIT,
        ST_PLL_WAIT,
        ST_IRQ
    } seq_state_e;

    localparam int NUM_SRC  = 3;
    localparam int SRC_BUS  = 0;
    localparam int SRC_MAIN = 1;
    localparam int SRC_AUX  = 2;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CFG   = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;
    localparam logic [1:0] ADDR_DELAY = 2'd3;

    localparam int CFG_MAIN_POL = 0;
    localparam int CFG_AUX_POL  = 1;
    localparam int CFG_AUX_GPIO = 2;
    localparam int CFG_W        = 3;

endpackage

// File: rtl/wake_sync.sv
module wake_sync
    import pwr_wake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] act_high_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic [NUM_SRC-1:0] req_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_SRC-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0] = raw_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            sync_d.pipe[s] = sync_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        logic lvl;
        assign lvl      = sync_q.pipe[SYNC_STAGES-1][g];
        assign req_o[g] = enable_i[g] & (act_high_i[g] ? lvl : ~lvl);
    end

endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import pwr_wake_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 8,
    parameter int DEF_DELAY = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [1:0]         addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_SRC-1:0] flag_set_i,
    input  logic               pd_clr_i,
    output logic               pd_req_o,
    output logic [CFG_W-1:0]   cfg_o,
    output logic [CNT_W-1:0]   delay_o
);

    typedef struct packed {
        logic               pd;
        logic [CFG_W-1:0]   cfg;
        logic [NUM_SRC-1:0] stat;
        logic [CNT_W-1:0]   dly;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            case (addr_i)
                ADDR_CTRL:  if (wdata_i[0]) regs_d.pd = 1'b1;
                ADDR_CFG:   regs_d.cfg  = wdata_i[CFG_W-1:0];
                ADDR_STAT:  regs_d.stat = regs_q.stat & ~wdata_i[NUM_SRC-1:0];
                default:    regs_d.dly  = wdata_i[CNT_W-1:0];
            endcase
        end
        regs_d.stat = regs_d.stat | flag_set_i;
        if (pd_clr_i) regs_d.pd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.dly  <= CNT_W'(DEF_DELAY);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (addr_i)
            ADDR_CTRL:  rdata_o = DATA_W'(regs_q.pd);
            ADDR_CFG:   rdata_o = DATA_W'(regs_q.cfg);
            ADDR_STAT:  rdata_o = DATA_W'(regs_q.stat);
            default:    rdata_o = DATA_W'(regs_q.dly);
        endcase
    end

    assign pd_req_o = regs_q.pd;
    assign cfg_o    = regs_q.cfg;
    assign delay_o  = regs_q.dly;

    // R9: flags are only latched while power-down is requested
    p_flags_only_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set_i) |-> regs_q.pd);

    // R7: auxiliary flag never set in general-purpose mode
    p_aux_gpio_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set_i[SRC_AUX] |-> !regs_q.cfg[CFG_AUX_GPIO]);

endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import pwr_wake_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_req_i,
    input  logic [NUM_SRC-1:0] wake_req_i,
    input  logic               pll_locked_i,
    input  logic [CNT_W-1:0]   delay_i,
    output logic               osc_en_o,
    output logic               pll_en_o,
    output logic               irq_o,
    output logic               pd_clr_o,
    output logic [NUM_SRC-1:0] flag_set_o
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        flag_set_o = '0;
        irq_o      = 1'b0;
        pd_clr_o   = 1'b0;
        case (fsm_q.st)
            ST_RUN: begin
                if (pd_req_i) fsm_d.st = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (|wake_req_i) begin
                    fsm_d.st   = ST_OSC_WAIT;
                    fsm_d.cnt  = delay_i;
                    flag_set_o = wake_req_i;
                end
            end
            ST_OSC_WAIT: begin
                if (fsm_q.cnt == '0) fsm_d.st  = ST_PLL_WAIT;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            ST_PLL_WAIT: begin
                if (pll_locked_i) fsm_d.st = ST_IRQ;
            end
            ST_IRQ: begin
                irq_o    = 1'b1;
                pd_clr_o = 1'b1;
                fsm_d.st = ST_RUN;
            end
            default: fsm_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_RUN;
            fsm_q.cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign osc_en_o = (fsm_q.st != ST_SLEEP);
    assign pll_en_o = (fsm_q.st == ST_RUN) || (fsm_q.st == ST_PLL_WAIT) ||
                      (fsm_q.st == ST_IRQ);

    // R5: interrupt only follows a sampled lock
    p_irq_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(pll_locked_i));

    // R2: no wake sequence starts unless power-down was requested
    p_sleep_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_SLEEP) |-> pd_req_i);

endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
    import pwr_wake_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int DEF_DELAY   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_activity,
    input  logic              main_wake_pin,
    input  logic              aux_wake_pin,
    input  logic              pll_locked,
    output logic              osc_en,
    output logic              pll_en,
    output logic              wake_irq
);

    logic [NUM_SRC-1:0] raw_src, act_high, src_en, wake_req, flag_set;
    logic [CFG_W-1:0]   cfg;
    logic [CNT_W-1:0]   delay;
    logic               pd_req, pd_clr;

    always_comb begin
        raw_src            = '0;
        raw_src[SRC_BUS]   = bus_activity;
        raw_src[SRC_MAIN]  = main_wake_pin;
        raw_src[SRC_AUX]   = aux_wake_pin;
        act_high           = '0;
        act_high[SRC_BUS]  = 1'b1;
        act_high[SRC_MAIN] = cfg[CFG_MAIN_POL];
        act_high[SRC_AUX]  = cfg[CFG_AUX_POL];
        src_en             = '1;
        src_en[SRC_AUX]    = ~cfg[CFG_AUX_GPIO];
    end

    wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (raw_src),
        .act_high_i (act_high),
        .enable_i   (src_en),
        .req_o      (wake_req)
    );

    wake_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_DELAY(DEF_DELAY)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .flag_set_i (flag_set),
        .pd_clr_i   (pd_clr),
        .pd_req_o   (pd_req),
        .cfg_o      (cfg),
        .delay_o    (delay)
    );

    wake_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_req_i     (pd_req),
        .wake_req_i   (wake_req),
        .pll_locked_i (pll_locked),
        .delay_i      (delay),
        .osc_en_o     (osc_en),
        .pll_en_o     (pll_en),
        .irq_o        (wake_irq),
        .pd_clr_o     (pd_clr),
        .flag_set_o   (flag_set)
    );

    // R4: PLL only comes up with the oscillator already running
    p_pll_after_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> $past(osc_en));

    // R5: single-cycle interrupt
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    // R8: power-down request is gone after the interrupt
    p_pd_selfclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !pd_req);

    // R2: both clock enables are off together while sleeping
    p_clocks_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !pll_en);

endmodule

// File: tb/pwr_wake_seq_test.sv
module pwr_wake_seq_test;

    localparam int DW  = 8;
    localparam int DEF = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          bus_activity = 1'b0;
    logic          main_wake_pin = 1'b1;
    logic          aux_wake_pin = 1'b1;
    logic          pll_locked = 1'b0;
    logic          osc_en, pll_en, wake_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    pwr_wake_seq #(.DATA_W(DW), .CNT_W(8), .DEF_DELAY(DEF), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_activity(bus_activity), .main_wake_pin(main_wake_pin),
        .aux_wake_pin(aux_wake_pin), .pll_locked(pll_locked),
        .osc_en(osc_en), .pll_en(pll_en), .wake_irq(wake_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic wait_irq(input string req);
        int start;
        bit seen;
        start = irq_cnt;
        seen = 0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (irq_cnt > start) seen = 1;
        end
        chk(req, int'(seen), 1);
    endtask

    // scoreboard monitor: osc -> pll spacing and interrupt conditions
    initial begin
        bit prev_osc, prev_pll, counting, prev_irq;
        int cyc;
        prev_osc = 1; prev_pll = 1; counting = 0; cyc = 0; prev_irq = 0;
        forever begin
            @(negedge clk);
            if (counting) cyc++;
            if (osc_en && !prev_osc) begin counting = 1; cyc = 0; end
            if (pll_en && !prev_pll) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected pll rise", 1, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk("R4 osc-to-pll cycles", cyc, e + 1);
                end
                counting = 0;
            end
            if (wake_irq) begin
                irq_cnt++;
                chk("R5 lock held at irq", int'(pll_locked), 1);
                chk("R5 irq single pulse", int'(prev_irq), 0);
            end
            prev_osc = osc_en; prev_pll = pll_en; prev_irq = wake_irq;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 osc_en", int'(osc_en), 1);
        chk("R1 pll_en", int'(pll_en), 1);
        chk("R1 wake_irq", int'(wake_irq), 0);
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 cfg", v, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        rd(2'd3, v); chk("R1 delay", v, DEF);

        // R9 wake sources while awake are ignored
        bus_activity = 1; main_wake_pin = 0; aux_wake_pin = 0;
        repeat (10) @(negedge clk);
        bus_activity = 0; main_wake_pin = 1; aux_wake_pin = 1;
        repeat (5) @(negedge clk);
        rd(2'd2, v); chk("R9 status stays clear", v, 0);
        chk("R9 no irq", irq_cnt, 0);
        chk("R9 osc_en on", int'(osc_en), 1);

        // R2/R3/R4/R5/R8/R10 main pin wake, default delay, late lock
        pll_locked = 0;
        exp_q.push_back(DEF);
        wr(2'd0, 8'h01);
        @(negedge clk);
        chk("R2 osc_en off", int'(osc_en), 0);
        chk("R2 pll_en off", int'(pll_en), 0);
        rd(2'd0, v); chk("R2 ctrl reads 1", v, 1);
        repeat (5) @(negedge clk);
        chk("R2 stays asleep", int'(osc_en), 0);
        main_wake_pin = 0;
        repeat (2) @(negedge clk);
        chk("R3 osc still off after two edges", int'(osc_en), 0);
        @(negedge clk);
        chk("R3 osc on after third edge", int'(osc_en), 1);
        chk("R4 pll still off", int'(pll_en), 0);
        repeat (DEF + 1) @(negedge clk);
        chk("R4 pll on", int'(pll_en), 1);
        repeat (6) @(negedge clk);
        chk("R5 waits for lock", irq_cnt, 0);
        pll_locked = 1;
        wait_irq("R5 irq after lock");
        rd(2'd0, v); chk("R8 ctrl self-cleared", v, 0);
        rd(2'd2, v); chk("R10 main flag", v, 2);
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk("R10 w1c clears", v, 0);
        main_wake_pin = 1;
        repeat (4) @(negedge clk);

        // R4 lock held high throughout, bus wake, short delay; R10 write-0 keeps flag
        wr(2'd3, 8'd3);
        exp_q.push_back(3);
        wr(2'd0, 8'h01);
        repeat (3) @(negedge clk);
        bus_activity = 1;
        wait_irq("R4 bus wake completes");
        bus_activity = 0;
        rd(2'd2, v); chk("R10 bus flag", v, 1);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R10 write zero keeps", v, 1);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R10 cleared", v, 0);
        repeat (4) @(negedge clk);

        // R7 auxiliary pin as general-purpose input
        wr(2'd1, 8'h04);
        exp_q.push_back(3);
        wr(2'd0, 8'h01);
        @(negedge clk);
        aux_wake_pin = 0;
        repeat (20) @(negedge clk);
        chk("R7 gpio pin does not wake", int'(osc_en), 0);
        bus_activity = 1;
        wait_irq("R7 bus still wakes");
        bus_activity = 0;
        rd(2'd2, v); chk("R7 aux flag not set", v, 1);
        wr(2'd2, 8'h07);
        aux_wake_pin = 1;
        repeat (4) @(negedge clk);

        // R6 active-high polarity on both pins, zero delay
        main_wake_pin = 0; aux_wake_pin = 0;
        wr(2'd1, 8'h03);
        wr(2'd3, 8'd0);
        exp_q.push_back(0);
        wr(2'd0, 8'h01);
        @(negedge clk);
        main_wake_pin = 1; main_wake_pin = 0;
        repeat (10) @(negedge clk);
        chk("R6 low level ignored when active high", int'(osc_en), 0);
        aux_wake_pin = 1;
        wait_irq("R6 aux active-high wake");
        rd(2'd2, v); chk("R6 aux flag", v, 4);
        wr(2'd2, 8'h07);
        aux_wake_pin = 0;
        repeat (4) @(negedge clk);

        // R10 two sources together, back to active low
        main_wake_pin = 1; aux_wake_pin = 1;
        wr(2'd1, 8'h00);
        exp_q.push_back(0);
        wr(2'd0, 8'h01);
        @(negedge clk);
        main_wake_pin = 0; bus_activity = 1;
        wait_irq("R10 dual wake");
        rd(2'd2, v); chk("R10 both flags", v, 3);
        main_wake_pin = 1; bus_activity = 0;
        repeat (4) @(negedge clk);

        chk("R5 total interrupts", irq_cnt, 5);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule